// File: doc/BRIEF.md
# Windowed Memory Page Mapper

This block sits between a 16-bit processor address bus and a larger physical memory system. It splits the 64 KB processor space into four 16 KB windows, using the top two address bits to pick one. The lowest window is fixed: it maps straight through to physical page 0 of RAM. Each of the three upper windows has its own 8-bit page number and its own 2-bit memory-type field. Together these steer an access to a 16 KB page of ROM, RAM or IO anywhere in a 22-bit physical space.

Software sets up the mapping through a small special-function-register port. The port has an 8-bit address, a write strobe, write data and combinational read data. The memory side gets the 22-bit physical address and one-hot chip selects for ROM, RAM and IO. The translation is combinational from the registered mapping state. A mapping write takes effect on the next access after the write edge.

Top module: `page_mapper`

## Requirements
- R1: After reset, all three page numbers and every type field read back as zero, so each upper window maps to ROM page 0.
- R2: A CPU address with bits [15:14] = 0 is not remapped: the physical address is {8'h00, addr[13:0]} and RAM is selected.
- R3: For an address with bits [15:14] = w (w = 1, 2, 3), the physical address is {page_w, addr[13:0]}. The page registers for w = 1, 2, 3 sit at SFR addresses 0x9B, 0x9C and 0x9D.
- R4: The type register at SFR 0x9A holds the type of window 1 in bits [1:0], window 2 in bits [3:2] and window 3 in bits [5:4]. Code 0 asserts rom_cs_o, code 1 asserts ram_cs_o and code 2 asserts io_cs_o. At most one chip select is high.
- R5: An access through a window whose type code is 3 asserts no chip select.
- R6: No chip select is asserted while mem_en_i is low.
- R7: SFR reads of 0x9A to 0x9D return the current register values, with bits [7:6] of 0x9A reading zero. Any other SFR address reads zero.
- R8: A mapping write changes the translation starting with the first cycle after its write clock edge. During the write cycle itself, the old mapping applies.
- R9: Writes to SFR addresses outside 0x9A to 0x9D change no mapping and no readback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_addr_i | input | 8 | SFR address |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data (combinational) |
| mem_en_i | input | 1 | Memory access in progress |
| cpu_addr_i | input | 16 | Processor address |
| phys_addr_o | output | 22 | Physical address |
| rom_cs_o | output | 1 | ROM select |
| ram_cs_o | output | 1 | RAM select |
| io_cs_o | output | 1 | IO select |

## Verification
The physical address, the chip selects and the SFR read data are combinational, so the bench drives new inputs at the falling edge and checks them a couple of nanoseconds later, in the same cycle. A mapping write only lands at the next rising edge. The bench therefore checks the old translation while the strobe is still high. It updates its own register model only after that edge, and then checks the new translation one cycle after the write.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CPU_AW  = 16;
  localparam int OFF_W   = 14;
  localparam int PAGE_W  = 8;
  localparam int PHYS_AW = PAGE_W + OFF_W;
  localparam int WIN_W   = CPU_AW - OFF_W;
  localparam int NUM_WIN = 1 << WIN_W;

  typedef enum logic [1:0] {
    MT_ROM  = 2'd0,
    MT_RAM  = 2'd1,
    MT_IO   = 2'd2,
    MT_RSVD = 2'd3
  } mem_type_e;
endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter logic [7:0] TYPE_ADDR = 8'h9A,
  parameter logic [7:0] PAGE_BASE = 8'h9B
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [7:0]                           sfr_addr_i,
  input  logic                                 sfr_we_i,
  input  logic [7:0]                           sfr_wdata_i,
  output logic [7:0]                           sfr_rdata_o,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]       page_o,
  output mem_type_e [NUM_WIN-1:0]              type_o
);
  localparam int TYPE_BITS = 2 * (NUM_WIN - 1);

  logic [TYPE_BITS-1:0] type_q;
  logic [PAGE_W-1:0]    page_q [NUM_WIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) type_q <= '0;
    else if (sfr_we_i && sfr_addr_i == TYPE_ADDR) type_q <= sfr_wdata_i[TYPE_BITS-1:0];
  end

  // window 0 is fixed: RAM page 0
  assign page_q[0] = '0;
  assign page_o[0] = '0;
  assign type_o[0] = MT_RAM;

  for (genvar w = 1; w < NUM_WIN; w++) begin : g_win
    localparam logic [7:0] WADDR = 8'(PAGE_BASE + 8'(w - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) page_q[w] <= '0;
      else if (sfr_we_i && sfr_addr_i == WADDR) page_q[w] <= sfr_wdata_i[PAGE_W-1:0];
    end
    assign page_o[w] = page_q[w];
    assign type_o[w] = mem_type_e'(type_q[2*(w-1) +: 2]);
  end

  always_comb begin
    sfr_rdata_o = '0;
    if (sfr_addr_i == TYPE_ADDR) sfr_rdata_o = 8'(type_q);
    for (int w = 1; w < NUM_WIN; w++) begin
      if (sfr_addr_i == 8'(PAGE_BASE + 8'(w - 1))) sfr_rdata_o = 8'(page_q[w]);
    end
  end
endmodule

// File: rtl/pm_decode.sv
module pm_decode
  import pm_pkg::*;
(
  input  logic [CPU_AW-1:0]               cpu_addr_i,
  input  logic                            mem_en_i,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]  page_i,
  input  mem_type_e [NUM_WIN-1:0]         type_i,
  output logic [PHYS_AW-1:0]              phys_addr_o,
  output logic                            rom_cs_o,
  output logic                            ram_cs_o,
  output logic                            io_cs_o
);
  logic [WIN_W-1:0] win;
  mem_type_e        sel_type;

  assign win         = cpu_addr_i[CPU_AW-1 -: WIN_W];
  assign sel_type    = type_i[win];
  assign phys_addr_o = {page_i[win], cpu_addr_i[OFF_W-1:0]};

  always_comb begin
    rom_cs_o = 1'b0;
    ram_cs_o = 1'b0;
    io_cs_o  = 1'b0;
    if (mem_en_i) begin
      unique case (sel_type)
        MT_ROM:  rom_cs_o = 1'b1;
        MT_RAM:  ram_cs_o = 1'b1;
        MT_IO:   io_cs_o  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pm_pkg::*;
#(
  parameter logic [7:0] TYPE_ADDR = 8'h9A,
  parameter logic [7:0] PAGE_BASE = 8'h9B
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           sfr_addr_i,
  input  logic                 sfr_we_i,
  input  logic [7:0]           sfr_wdata_i,
  output logic [7:0]           sfr_rdata_o,
  input  logic                 mem_en_i,
  input  logic [CPU_AW-1:0]    cpu_addr_i,
  output logic [PHYS_AW-1:0]   phys_addr_o,
  output logic                 rom_cs_o,
  output logic                 ram_cs_o,
  output logic                 io_cs_o
);
  logic [NUM_WIN-1:0][PAGE_W-1:0] page;
  mem_type_e [NUM_WIN-1:0]        wtype;

  pm_regs #(.TYPE_ADDR(TYPE_ADDR), .PAGE_BASE(PAGE_BASE)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sfr_addr_i  (sfr_addr_i),
    .sfr_we_i    (sfr_we_i),
    .sfr_wdata_i (sfr_wdata_i),
    .sfr_rdata_o (sfr_rdata_o),
    .page_o      (page),
    .type_o      (wtype)
  );

  pm_decode u_dec (
    .cpu_addr_i  (cpu_addr_i),
    .mem_en_i    (mem_en_i),
    .page_i      (page),
    .type_i      (wtype),
    .phys_addr_o (phys_addr_o),
    .rom_cs_o    (rom_cs_o),
    .ram_cs_o    (ram_cs_o),
    .io_cs_o     (io_cs_o)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker
  import pm_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          sfr_addr_i,
  input logic                sfr_we_i,
  input logic [7:0]          sfr_wdata_i,
  input logic [7:0]          sfr_rdata_o,
  input logic                mem_en_i,
  input logic [CPU_AW-1:0]   cpu_addr_i,
  input logic [PHYS_AW-1:0]  phys_addr_o,
  input logic                rom_cs_o,
  input logic                ram_cs_o,
  input logic                io_cs_o
);
  a_r4_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, ram_cs_o, io_cs_o}));

  a_r6_idle_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |-> !(rom_cs_o || ram_cs_o || io_cs_o));

  a_r2_low_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_i && cpu_addr_i[15:14] == 2'd0) |->
      (ram_cs_o && phys_addr_o == {8'h00, cpu_addr_i[13:0]}));

  a_r3_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[13:0] == cpu_addr_i[13:0]);

  a_r7_type_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_addr_i == 8'h9A |-> sfr_rdata_o[7:6] == 2'b00);

  a_r8_page_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_i && sfr_addr_i == 8'h9B) |=>
      (cpu_addr_i[15:14] != 2'd1 || phys_addr_o[21:14] == $past(sfr_wdata_i)));
endmodule

bind page_mapper pm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sfr_addr_i  (sfr_addr_i),
  .sfr_we_i    (sfr_we_i),
  .sfr_wdata_i (sfr_wdata_i),
  .sfr_rdata_o (sfr_rdata_o),
  .mem_en_i    (mem_en_i),
  .cpu_addr_i  (cpu_addr_i),
  .phys_addr_o (phys_addr_o),
  .rom_cs_o    (rom_cs_o),
  .ram_cs_o    (ram_cs_o),
  .io_cs_o     (io_cs_o)
);

// File: tb/sim_page_mapper.sv
`timescale 1ns/1ps
module sim_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        mem_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [21:0] phys;
  logic        rom_cs, ram_cs, io_cs;

  int checks = 0;
  int fails = 0;

  logic [5:0] m_type;
  logic [7:0] m_page [1:3];

  always #4 clk = ~clk;

  page_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sfr_addr_i(sfr_addr), .sfr_we_i(sfr_we), .sfr_wdata_i(sfr_wdata),
    .sfr_rdata_o(sfr_rdata), .mem_en_i(mem_en), .cpu_addr_i(cpu_addr),
    .phys_addr_o(phys), .rom_cs_o(rom_cs), .ram_cs_o(ram_cs), .io_cs_o(io_cs)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_phys(input logic [15:0] a);
    logic [1:0] w = a[15:14];
    return (w == 0) ? {8'h00, a[13:0]} : {m_page[w], a[13:0]};
  endfunction

  // {io, ram, rom}
  function automatic logic [2:0] exp_cs(input logic [15:0] a, input logic en);
    logic [1:0] w = a[15:14];
    logic [1:0] t = (w == 0) ? 2'd1 : m_type[2*(w-1) +: 2];
    if (!en) return 3'b000;
    case (t)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h9A: return {2'b00, m_type};
      8'h9B: return m_page[1];
      8'h9C: return m_page[2];
      8'h9D: return m_page[3];
      default: return 8'h00;
    endcase
  endfunction

  // drive at negedge, check combinational outputs 2 ns later
  task automatic access(input logic [15:0] a, input logic en, input string req);
    @(negedge clk);
    sfr_we = 1'b0; cpu_addr = a; mem_en = en;
    #2;
    check(phys == exp_phys(a), req, 32'(phys), 32'(exp_phys(a)));
    check({io_cs, ram_cs, rom_cs} == exp_cs(a, en), req,
          32'({io_cs, ram_cs, rom_cs}), 32'(exp_cs(a, en)));
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = a;
    #2;
    check(sfr_rdata == exp_rd(a), req, 32'(sfr_rdata), 32'(exp_rd(a)));
  endtask

  // write; during the write cycle the old mapping must hold (R8)
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [15:0] probe);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1; cpu_addr = probe; mem_en = 1'b1;
    #2;
    check(phys == exp_phys(probe), "R8 old map in write cycle", 32'(phys), 32'(exp_phys(probe)));
    check({io_cs, ram_cs, rom_cs} == exp_cs(probe, 1'b1), "R8 old cs in write cycle",
          32'({io_cs, ram_cs, rom_cs}), 32'(exp_cs(probe, 1'b1)));
    @(posedge clk);
    #1;
    case (a)
      8'h9A: m_type = d[5:0];
      8'h9B: m_page[1] = d;
      8'h9C: m_page[2] = d;
      8'h9D: m_page[3] = d;
      default: ;
    endcase
    sfr_we = 1'b0;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_type = '0;
    for (int i = 1; i < 4; i++) m_page[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 8'h9A; a <= 8'h9D; a++) rd(8'(a), "R1 reset readback");
    access(16'h4123, 1'b1, "R1 reset window1 ROM page0");
    access(16'hFFFF, 1'b1, "R1 reset window3 ROM page0");

    // R2 low window
    access(16'h0000, 1'b1, "R2 low window base");
    access(16'h3FFF, 1'b1, "R2 low window top");

    // R3 / R4 directed
    wr(8'h9B, 8'h05, 16'h4010);
    access(16'h4010, 1'b1, "R3 window1 page5");
    wr(8'h9C, 8'hFF, 16'h8000);
    access(16'hBFFF, 1'b1, "R3 window2 page FF");
    wr(8'h9D, 8'h80, 16'hC001);
    access(16'hC001, 1'b1, "R3 window3 char ROM region");
    wr(8'h9A, 8'b11_10_01_00, 16'h4000);
    access(16'h4000, 1'b1, "R4 window1 ROM");
    access(16'h8000, 1'b1, "R4 window2 RAM");
    access(16'hC000, 1'b1, "R4 window3 IO");
    rd(8'h9A, "R7 type bits 7:6 read zero");

    // R5 reserved type
    wr(8'h9A, 8'b00_11_11_11, 16'h8000);
    access(16'h5000, 1'b1, "R5 reserved type no cs");
    access(16'hE000, 1'b1, "R5 reserved type no cs");
    access(16'h1000, 1'b1, "R2 low window unaffected by type");

    // R6 idle
    access(16'h4000, 1'b0, "R6 no cs when idle");
    access(16'h0000, 1'b0, "R6 no cs when idle");

    // R9 other addresses ignored
    wr(8'h99, 8'hAA, 16'h4000);
    wr(8'h9E, 8'h55, 16'h4000);
    for (int a = 8'h98; a <= 8'h9F; a++) rd(8'(a), "R9 R7 readback after stray writes");
    access(16'hC123, 1'b1, "R9 mapping unchanged");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 3);
      logic [15:0] a = 16'($urandom);
      if (op == 0) wr(8'(8'h98 + $urandom_range(0, 7)), 8'($urandom), a);
      else if (op == 1) rd(8'(8'h98 + $urandom_range(0, 7)), "R7 random readback");
      else access(a, 1'($urandom_range(0, 3) != 0), "R3 R4 random access");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule